// File: doc/BRIEF.md
# Cache line occupancy and age monitor

This block shadows the line array of a set-associative cache with a small record per line: whether the line is resident, which task owns it, and the cycle on which that ownership began. The cache controller sends it one event strobe per cycle. A fill records the requester's task, and a fill raised by the hardware prefetcher is booked under a reserved prefetcher task. An invalidation releases the line. A writeback hands out the line's owner on a side output and then returns the line to the Unknown task.

Statistics are not kept as events arrive. When a dump is requested, the monitor clears every counter and then walks all lines, one per clock. Each resident line adds one to its task's occupancy count. It also adds one to a single bin of that task's age histogram. The age is the free-running cycle count minus the line's recorded cycle, sorted into five bins by four cycle thresholds. When the walk ends the monitor raises `done`, and software-facing logic reads any counter through a small address/data port.

Top module: `occ_age_monitor`

## Requirements
- R1: After reset every line is non-resident and owned by task 0 (Unknown). `busy` and `done` are low and every read returns 0.
- R2: A fill (`ev_op`=1) makes the line resident and records the current cycle. The owner is `ev_tid`, or the prefetcher task `TASKS-1` (3 by default) when `ev_pf` is high.
- R3: An invalidate (`ev_op`=2) makes the line non-resident, sets its owner to Unknown and restarts its age. It is no longer counted.
- R4: During a writeback (`ev_op`=3), `wb_tid` shows the line's current owner in that same cycle. Afterwards the line stays resident, is owned by Unknown and has age 0 from that cycle.
- R5: A dump accepted while idle clears all occupancy and histogram counters, so results never carry over from an earlier dump.
- R6: The walk visits line i on the (i+1)-th clock after the dump is accepted. `busy` is high for `LINES` cycles, and `done` rises on the clock that visits the last line.
- R7: Age sorts into bin 0 below `AGE_T0`, bin 1 below `AGE_T1`, bin 2 below `AGE_T2`, bin 3 below `AGE_T3`, and otherwise bin 4. An age equal to a threshold lands in the higher bin.
- R8: Events that arrive during a walk update the records. A line is counted with the value it held just before the clock that visits it, so an event on the visiting clock is not seen.
- R9: A recorded owner of `TASKS` or above is counted as task 0.
- R10: `done` stays high until the next accepted dump. A dump request while `busy` is ignored.
- R11: With `rd_hist`=0, `rd_data` is the occupancy of `rd_task`. With `rd_hist`=1 it is bin `rd_bin` of that task. Bin codes above 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| ev_op | input | 2 | event: 0 none, 1 fill, 2 invalidate, 3 writeback |
| ev_line | input | $clog2(LINES) | line index of the event |
| ev_tid | input | TID_W | task of a fill |
| ev_pf | input | 1 | fill comes from the prefetcher |
| wb_tid | output | TID_W | owner of line `ev_line` |
| dump | input | 1 | start a statistics walk |
| busy | output | 1 | walk in progress |
| done | output | 1 | results valid |
| rd_hist | input | 1 | read selects a histogram bin instead of occupancy |
| rd_task | input | $clog2(TASKS) | task to read |
| rd_bin | input | 3 | histogram bin to read |
| rd_data | output | $clog2(LINES+1) | read result |

## Verification
The bench places fills so that one line's age equals each threshold exactly and a neighbouring line sits one cycle below it. A design that compared with less-or-equal would move the first line down a bin. The bench fires events on lines before, on and after the walk position. A walk that read the records one clock late or early would then count the wrong owner for those lines. It dumps twice in a row after invalidations and a writeback, which catches counters that accumulate instead of clearing. It also stores owners beyond the task range, to check that they fold into task 0 rather than vanish.

// File: rtl/occ_age_monitor.sv
module occ_age_monitor #(
  parameter int LINES   = 8,
  parameter int TASKS   = 4,
  parameter int TID_W   = 3,
  parameter int TS_W    = 16,
  parameter int AGE_T0  = 8,
  parameter int AGE_T1  = 32,
  parameter int AGE_T2  = 128,
  parameter int AGE_T3  = 512,
  localparam int LW = $clog2(LINES),
  localparam int TW = $clog2(TASKS),
  localparam int CW = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ev_op,
  input  logic [LW-1:0]    ev_line,
  input  logic [TID_W-1:0] ev_tid,
  input  logic             ev_pf,
  output logic [TID_W-1:0] wb_tid,
  input  logic             dump,
  output logic             busy,
  output logic             done,
  input  logic             rd_hist,
  input  logic [TW-1:0]    rd_task,
  input  logic [2:0]       rd_bin,
  output logic [CW-1:0]    rd_data
);
  localparam logic [1:0] OP_FILL = 2'd1, OP_INV = 2'd2, OP_WB = 2'd3;
  localparam logic [TID_W-1:0] UNK = '0;
  localparam logic [TID_W-1:0] PF  = TID_W'(TASKS - 1);
  localparam logic [TID_W:0]   TASKS_V = (TID_W + 1)'(TASKS);
  localparam logic [TS_W-1:0]  TH0 = TS_W'(AGE_T0), TH1 = TS_W'(AGE_T1),
                               TH2 = TS_W'(AGE_T2), TH3 = TS_W'(AGE_T3);

  logic             vld  [LINES];
  logic [TID_W-1:0] tid  [LINES];
  logic [TS_W-1:0]  tins [LINES];
  logic [TS_W-1:0]  ts;
  logic [LW-1:0]    idx;
  logic [CW-1:0]    occ  [TASKS];
  logic [CW-1:0]    hist [TASKS][5];

  logic [TID_W-1:0] s_tid;
  logic [TW-1:0]    s_task;
  logic [TS_W-1:0]  s_age;
  logic [2:0]       s_bin;

  assign wb_tid = tid[ev_line];
  assign s_tid  = tid[idx];
  assign s_task = ({1'b0, s_tid} < TASKS_V) ? TW'(s_tid) : TW'(UNK);
  assign s_age  = ts - tins[idx];

  always_comb begin
    if      (s_age < TH0) s_bin = 3'd0;
    else if (s_age < TH1) s_bin = 3'd1;
    else if (s_age < TH2) s_bin = 3'd2;
    else if (s_age < TH3) s_bin = 3'd3;
    else                  s_bin = 3'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= ts + TS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        vld[i]  <= 1'b0;
        tid[i]  <= UNK;
        tins[i] <= '0;
      end
    end else begin
      case (ev_op)
        OP_FILL: begin
          vld[ev_line]  <= 1'b1;
          tid[ev_line]  <= ev_pf ? PF : ev_tid;
          tins[ev_line] <= ts;
        end
        OP_INV: begin
          vld[ev_line]  <= 1'b0;
          tid[ev_line]  <= UNK;
          tins[ev_line] <= ts;
        end
        OP_WB: begin
          tid[ev_line]  <= UNK;
          tins[ev_line] <= ts;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (dump && !busy)) begin
      busy <= !rst;
      done <= 1'b0;
      idx  <= '0;
      for (int t = 0; t < TASKS; t++) begin
        occ[t] <= '0;
        for (int b = 0; b < 5; b++) hist[t][b] <= '0;
      end
    end else if (busy) begin
      if (vld[idx]) begin
        occ[s_task]         <= occ[s_task] + CW'(1);
        hist[s_task][s_bin] <= hist[s_task][s_bin] + CW'(1);
      end
      if (idx == LW'(LINES - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + LW'(1);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if ({1'b0, rd_task} < (TW + 1)'(TASKS)) begin
      if (!rd_hist)          rd_data = occ[rd_task];
      else if (rd_bin < 3'd5) rd_data = hist[rd_task][rd_bin];
    end
  end
endmodule

// File: rtl/occ_age_monitor_chk.sv
module occ_age_monitor_chk #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    ev_op,
  input logic [LW-1:0] ev_line,
  input logic          dump,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] idx,
  input logic          vld [LINES]
);
  p_fill_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_op == 2'd1 |=> vld[$past(ev_line)]);

  p_inval_clears_r3: assert property (@(posedge clk) disable iff (rst)
    ev_op == 2'd2 |=> !vld[$past(ev_line)]);

  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    dump && !busy |=> busy && !done);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_finish_r6: assert property (@(posedge clk) disable iff (rst)
    busy && idx == LW'(LINES - 1) |=> done && !busy);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    done && !dump |=> done);
endmodule

bind occ_age_monitor occ_age_monitor_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .ev_op(ev_op), .ev_line(ev_line), .dump(dump),
  .busy(busy), .done(done), .idx(idx), .vld(vld)
);

// File: tb/occ_age_monitor_bench.sv
`timescale 1ns/1ps
module occ_age_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8, TASKS = 4;
  localparam int T0 = 8, T1 = 32, T2 = 128, T3 = 512;

  logic clk = 0, rst = 1;
  logic [1:0] ev_op = 0;
  logic [2:0] ev_line = 0, ev_tid = 0, wb_tid, rd_bin = 0;
  logic ev_pf = 0, dump = 0, busy, done, rd_hist = 0;
  logic [1:0] rd_task = 0;
  logic [3:0] rd_data;

  occ_age_monitor u_occ_age_monitor (
    .clk(clk), .rst(rst), .ev_op(ev_op), .ev_line(ev_line), .ev_tid(ev_tid),
    .ev_pf(ev_pf), .wb_tid(wb_tid), .dump(dump), .busy(busy), .done(done),
    .rd_hist(rd_hist), .rd_task(rd_task), .rd_bin(rd_bin), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, sc = -1;
  bit exp_done = 0;
  int mv[LINES], mt[LINES], mtime[LINES];
  int sv[LINES], st[LINES], sage[LINES];

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int bin_of(input int a);
    if (a < T0) return 0;
    if (a < T1) return 1;
    if (a < T2) return 2;
    if (a < T3) return 3;
    return 4;
  endfunction

  task automatic step(input int op, input int line = 0, input int t = 0,
                      input bit pf = 0, input bit dmp = 0);
    bit was_scan;
    @(negedge clk);
    ev_op = op[1:0]; ev_line = line[2:0]; ev_tid = t[2:0]; ev_pf = pf; dump = dmp;
    was_scan = (sc >= 0);
    if (op == 3) begin
      #1 chk("R4 wb_tid", wb_tid, mt[line]);
    end
    if (sc >= 0) begin
      sv[sc] = mv[sc]; st[sc] = mt[sc]; sage[sc] = (cyc - mtime[sc]) & 16'hFFFF;
      sc++;
      if (sc == LINES) begin sc = -1; exp_done = 1; end
    end
    if (dmp && !was_scan) begin sc = 0; exp_done = 0; end
    case (op)
      1: begin mv[line] = 1; mt[line] = pf ? TASKS - 1 : t; mtime[line] = cyc; end
      2: begin mv[line] = 0; mt[line] = 0; mtime[line] = cyc; end
      3: begin mt[line] = 0; mtime[line] = cyc; end
      default: ;
    endcase
    @(posedge clk); #1;
    ev_op = 0; dump = 0; ev_pf = 0;
    chk("R6 busy", busy, sc >= 0);
    chk("R10 done", done, exp_done);
  endtask

  task automatic verify(input string tag);
    int eo[TASKS];
    int eh[TASKS][5];
    foreach (eo[i]) eo[i] = 0;
    foreach (eh[i, j]) eh[i][j] = 0;
    for (int i = 0; i < LINES; i++)
      if (sv[i] != 0) begin
        int tk = (st[i] < TASKS) ? st[i] : 0;
        eo[tk]++;
        eh[tk][bin_of(sage[i])]++;
      end
    for (int t = 0; t < TASKS; t++) begin
      rd_task = t[1:0]; rd_hist = 0; #1;
      chk({tag, " R11 occupancy"}, rd_data, eo[t]);
      for (int b = 0; b < 6; b++) begin
        rd_hist = 1; rd_bin = b[2:0]; #1;
        chk({tag, " R7 bin"}, rd_data, (b < 5) ? eh[t][b] : 0);
      end
    end
  endtask

  task automatic run_dump(input string tag);
    step(0, 0, 0, 0, 1);
    repeat (LINES) step(0);
    verify(tag);
  endtask

  task automatic idle_until(input int when);
    while (cyc < when) step(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = 0; mtime[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    for (int t = 0; t < TASKS; t++) begin
      rd_task = t[1:0]; rd_hist = 0; #1;
      chk("R1 read", rd_data, 0);
    end
    rst = 0;
    run_dump("R1 empty");

    // R2 R9: various owners, prefetch, out-of-range tids
    step(1, 0, 1); step(1, 1, 2); step(1, 2, 1, 1); step(1, 3, 5);
    repeat (20) step(0);
    step(1, 4, 7); step(1, 5, 2); step(1, 6, 0, 1);
    repeat (150) step(0);
    step(1, 7, 1);
    run_dump("R2 R9 fill");

    // R3 R4 R5: invalidate, writeback, fresh counters
    step(2, 1); step(2, 2); step(3, 0); step(3, 5);
    run_dump("R3 R4 R5 first");
    run_dump("R5 second");

    // R7 thresholds: one line exactly at threshold, one just below
    for (int k = 0; k < 4; k++) begin
      int th = (k == 0) ? T0 : (k == 1) ? T1 : (k == 2) ? T2 : T3;
      int f;
      for (int i = 0; i < LINES; i++) step(2, i);
      f = cyc;
      step(1, 0, 1); step(0); step(1, 1, 2);
      idle_until(f + th - 1);
      run_dump("R7 threshold");
    end

    // R8 R10: events during a walk, ignored dump, done held
    for (int i = 0; i < LINES; i++) step(1, i, 1);
    step(0, 0, 0, 0, 1);
    step(1, 5, 2);
    step(0);
    step(2, 6, 0, 0, 1);
    step(2, 3);
    step(2, 2);
    repeat (LINES - 5) step(0);
    verify("R8 midscan");
    repeat (5) step(0);
    chk("R10 done held", done, 1);
    run_dump("R10 redump");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule